// File: doc/BRIEF.md
# Converter Conversion Control Interface

This block is the host-side control logic for a 12-bit converter placed behind an 8-bit register bus. The host picks one of eight analog inputs through a shared control byte and writes the start register to begin a conversion. It then polls a busy bit in the status register. When the converter reports completion, the block captures the 12-bit code in a holding register. The host reads that code as a low byte and then a high byte, with the top four bits of the code in the lower nibble of the high byte.

The converter itself is outside the block. It is reached through a small handshake: a one-cycle start pulse goes out, and a done strobe comes back with the 12-bit code. A board strap chooses unipolar (unsigned) or bipolar (two's complement) coding. The strap is synchronised and shown as a status bit. The code bits pass through unchanged in both codings.

Register offsets: 0 control (write), 1 start (write), 2 result low byte (read), 3 result high byte (read), 4 status (read). Status bit 0 is busy and status bit 1 is unipolar. The other status bits read 0.

Top module: `adc_ctrl`

## Requirements
- R1: After reset the busy bit is 0, the held result is 0, `chan_sel` is 0 and `conv_start` is low. Reset during a conversion returns the block to this state.
- R2: A write of any value to offset 1 while the block is idle raises `conv_start` for exactly one cycle. From the next clock edge, status bit 0 (busy) reads 1.
- R3: Busy stays 1 until `conv_done` is sampled high. On that edge busy clears and `conv_data` is loaded into the held result.
- R4: A read at offset 2 returns result bits 7..0. A read at offset 3 returns result bits 11..8 in bits 3..0, with bits 7..4 zero. The code is returned unchanged, so the bipolar extremes 0x800 and 0x7FF read back as written.
- R5: A write to offset 1 while busy is ignored: no second `conv_start` pulse and no restart. If `conv_done` arrives on the same edge, it is still taken.
- R6: The held result changes only on a completion taken while busy. Repeated reads return the same bytes, and a `conv_done` strobe while idle is ignored.
- R7: A write to offset 0 with bit 3 clear loads bits 2..0 into `chan_sel`. A write with bit 3 set leaves `chan_sel` unchanged.
- R8: Status bit 1 equals the `uni_strap` level after SYNC_STAGES clock edges (default 2). Status bits 7..2 read 0, unmapped offsets read 0, and `rd_data` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low local reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Read data, combinational from `rd_addr`, 0 when `rd_en` is low |
| uni_strap | input | 1 | Coding strap, 1 selects unipolar |
| chan_sel | output | 3 | Analog input channel select |
| conv_start | output | 1 | One-cycle conversion start pulse to the converter |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 12 | Converter output code, valid with `conv_done` |

## Verification
The hardest cases to reach are a start write on the same edge as the completion strobe, and a completion strobe that arrives while the block is idle. A real converter would never produce either one. The bench therefore drives the converter side as a scripted model. It places `conv_done` on exactly the cycle where a repeated start write lands, and it fires a stray strobe with a different code after the conversion has finished. The bench then reads both result bytes back to show which code was kept. The strap path is sampled one edge before and on the edge its delay predicts, so a short or long synchroniser is caught.

// File: rtl/adc_ctrl_pkg.sv
`timescale 1ns/1ps
package adc_ctrl_pkg;
   // Register offsets on the host bus.
   localparam int unsigned OFS_CTRL   = 0;
   localparam int unsigned OFS_START  = 1;
   localparam int unsigned OFS_RES_LO = 2;
   localparam int unsigned OFS_RES_HI = 3;
   localparam int unsigned OFS_STATUS = 4;

   // Status bit positions.
   localparam int unsigned STAT_BUSY = 0;
   localparam int unsigned STAT_UNI  = 1;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;
endpackage

// File: rtl/adc_ctrl_sync.sv
`timescale 1ns/1ps
module adc_ctrl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0 || STAGES > 8) begin : g_bad_stages
      $error("adc_ctrl_sync: STAGES must be 0..8");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= '0;
         end else begin
            r[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               r[i] <= r[i-1];
            end
         end
      end
      assign q = r[STAGES-1];
   end
endmodule

// File: rtl/adc_ctrl_seq.sv
`timescale 1ns/1ps
module adc_ctrl_seq
   import adc_ctrl_pkg::*;
#(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_data,
   output logic             busy,
   output logic             conv_start,
   output logic [RES_W-1:0] result
);
   seq_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         conv_start <= 1'b0;
         result     <= '0;
      end else begin
         conv_start <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start_req) begin
                  state_q    <= SEQ_BUSY;
                  conv_start <= 1'b1;
               end
            end
            SEQ_BUSY: begin
               if (conv_done) begin
                  state_q <= SEQ_IDLE;
                  result  <= conv_data;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy = (state_q == SEQ_BUSY);
endmodule

// File: rtl/adc_ctrl_regs.sv
`timescale 1ns/1ps
module adc_ctrl_regs
   import adc_ctrl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int RES_W  = 12,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              busy,
   input  logic              uni,
   input  logic [RES_W-1:0]  result,
   output logic              start_req,
   output logic [CH_W-1:0]   chan,
   output logic [DATA_W-1:0] rd_data
);
   localparam int HI_W    = RES_W - DATA_W;
   localparam int SEL_BIT = CH_W;

   logic wr_ctrl;
   logic [DATA_W-1:0] hi_byte;
   logic [DATA_W-1:0] status;

   assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
   assign start_req = wr_en && (wr_addr == ADDR_W'(OFS_START));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan <= '0;
      end else if (wr_ctrl && !wr_data[SEL_BIT]) begin
         chan <= wr_data[CH_W-1:0];
      end
   end

   if (HI_W == DATA_W) begin : g_hi_full
      assign hi_byte = result[RES_W-1:DATA_W];
   end else begin : g_hi_pad
      assign hi_byte = {{(DATA_W-HI_W){1'b0}}, result[RES_W-1:DATA_W]};
   end

   always_comb begin
      status            = '0;
      status[STAT_BUSY] = busy;
      status[STAT_UNI]  = uni;
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (rd_addr == ADDR_W'(OFS_RES_LO))      rd_data = result[DATA_W-1:0];
         else if (rd_addr == ADDR_W'(OFS_RES_HI)) rd_data = hi_byte;
         else if (rd_addr == ADDR_W'(OFS_STATUS)) rd_data = status;
         else                                     rd_data = '0;
      end
   end
endmodule

// File: rtl/adc_ctrl.sv
`timescale 1ns/1ps
module adc_ctrl #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int RES_W       = 12,
   parameter int CH_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              uni_strap,
   output logic [CH_W-1:0]   chan_sel,
   output logic              conv_start,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data
);
   if (RES_W <= DATA_W || RES_W > 2*DATA_W) begin : g_bad_res
      $error("adc_ctrl: RES_W must lie in (DATA_W, 2*DATA_W]");
   end
   if (CH_W + 1 > DATA_W) begin : g_bad_ch
      $error("adc_ctrl: channel field plus select bit must fit in DATA_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("adc_ctrl: ADDR_W must be at least 3");
   end

   logic             busy;
   logic             uni;
   logic             start_req;
   logic [RES_W-1:0] result;

   adc_ctrl_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (uni_strap),
      .q     (uni)
   );

   adc_ctrl_seq #(.RES_W(RES_W)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .conv_done  (conv_done),
      .conv_data  (conv_data),
      .busy       (busy),
      .conv_start (conv_start),
      .result     (result)
   );

   adc_ctrl_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .RES_W  (RES_W),
      .CH_W   (CH_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .busy      (busy),
      .uni       (uni),
      .result    (result),
      .start_req (start_req),
      .chan      (chan_sel),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/adc_ctrl_chk.sv
`timescale 1ns/1ps
module adc_ctrl_chk
   import adc_ctrl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int RES_W  = 12,
   parameter int CH_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [CH_W-1:0]   chan_sel,
   input logic              conv_start,
   input logic              conv_done,
   input logic [RES_W-1:0]  conv_data,
   input logic              busy,
   input logic [RES_W-1:0]  result
);
   logic start_wr;
   logic ctrl_wr;
   assign start_wr = wr_en && (wr_addr == ADDR_W'(OFS_START));
   assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));

   // R2
   start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && !busy) |=> (busy && conv_start));

   // R2
   start_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R3
   done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && conv_done) |=> (!busy && result == $past(conv_data)));

   // R3
   busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !conv_done) |=> busy);

   // R5
   start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && busy) |=> !conv_start);

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && conv_done) |=> $stable(result));

   // R7
   chan_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wr_data[CH_W]) |=> (chan_sel == $past(wr_data[CH_W-1:0])));

   // R7
   chan_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_wr && !wr_data[CH_W]) |=> $stable(chan_sel));

   // R4
   hi_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(OFS_RES_HI)) |-> (rd_data[DATA_W-1:RES_W-DATA_W] == '0));

   // R8
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0));
endmodule

bind adc_ctrl adc_ctrl_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .RES_W  (RES_W),
   .CH_W   (CH_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .chan_sel   (chan_sel),
   .conv_start (conv_start),
   .conv_done  (conv_done),
   .conv_data  (conv_data),
   .busy       (busy),
   .result     (result)
);

// File: tb/test_adc_ctrl.sv
`timescale 1ns/1ps
module test_adc_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        uni_strap = 1'b0;
   logic [2:0]  chan_sel;
   logic        conv_start;
   logic        conv_done = 1'b0;
   logic [11:0] conv_data = '0;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   adc_ctrl i_adc_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .uni_strap  (uni_strap),
      .chan_sel   (chan_sel),
      .conv_start (conv_start),
      .conv_done  (conv_done),
      .conv_data  (conv_data)
   );

   // {control byte, converter code, strap}
   localparam logic [20:0] VEC [6] = '{
      {8'h05, 12'h000, 1'b1},
      {8'h0A, 12'hFFF, 1'b1},
      {8'h02, 12'h800, 1'b0},
      {8'h07, 12'h7FF, 1'b0},
      {8'hF9, 12'hA5C, 1'b1},
      {8'h00, 12'h123, 1'b0}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      rd_en = 1'b1; rd_addr = a;
      #1 v = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic finish_conv(input logic [11:0] d);
      conv_done = 1'b1; conv_data = d;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         report();
         $finish;
      end
   end

   initial begin
      logic [7:0] v, lo, hi;
      logic [2:0] exp_chan;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 conv_start", 16'(conv_start), 16'h0);
      chk("R1 chan_sel", 16'(chan_sel), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(3'd4, v); chk("R1 status", 16'(v), 16'h00);
      rd(3'd2, v); chk("R1 result lo", 16'(v), 16'h00);
      rd(3'd3, v); chk("R1 result hi", 16'(v), 16'h00);

      exp_chan = 3'd0;
      for (int i = 0; i < 6; i++) begin
         logic [7:0]  c;
         logic [11:0] d;
         logic        s;
         {c, d, s} = VEC[i];
         uni_strap = s;
         // R7 channel select
         wr(3'd0, c);
         if (!c[3]) exp_chan = c[2:0];
         chk("R7 chan_sel", 16'(chan_sel), 16'(exp_chan));
         // R2 start with arbitrary data
         wr(3'd1, 8'h5A ^ 8'(i));
         chk("R2 conv_start pulse", 16'(conv_start), 16'h1);
         rd(3'd4, v); chk("R2 busy set", 16'(v[0]), 16'h1);
         repeat (3) @(negedge clk);
         chk("R2 single pulse", 16'(conv_start), 16'h0);
         rd(3'd4, v); chk("R3 busy held", 16'(v[0]), 16'h1);
         finish_conv(d);
         rd(3'd4, v);
         chk("R3 busy cleared", 16'(v[0]), 16'h0);
         chk("R8 unipolar bit", 16'(v[1]), 16'(s));
         chk("R8 status upper", 16'(v[7:2]), 16'h0);
         rd(3'd2, lo); rd(3'd3, hi);
         chk("R4 result lo", 16'(lo), 16'(d[7:0]));
         chk("R4 result hi", 16'(hi), 16'({4'h0, d[11:8]}));
         @(negedge clk);
         rd(3'd2, lo); rd(3'd3, hi);
         chk("R6 reread", 16'({hi, lo}), 16'({4'h0, d}));
      end

      // R5 start while busy is ignored
      wr(3'd1, 8'h00);
      @(negedge clk);
      wr(3'd1, 8'hFF);
      chk("R5 no second pulse", 16'(conv_start), 16'h0);
      rd(3'd4, v); chk("R5 still busy", 16'(v[0]), 16'h1);
      finish_conv(12'h3C6);
      rd(3'd4, v); chk("R5 busy cleared", 16'(v[0]), 16'h0);
      rd(3'd2, lo); rd(3'd3, hi);
      chk("R5 result", 16'({hi, lo}), 16'h03C6);
      @(negedge clk);
      chk("R5 no late pulse", 16'(conv_start), 16'h0);

      // R6 done while idle ignored
      finish_conv(12'hFFF);
      rd(3'd2, lo); rd(3'd3, hi);
      chk("R6 idle done ignored", 16'({hi, lo}), 16'h03C6);
      rd(3'd4, v); chk("R6 idle stays idle", 16'(v[0]), 16'h0);

      // R5 start write on the same edge as completion
      wr(3'd1, 8'h00);
      wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h00;
      conv_done = 1'b1; conv_data = 12'h9E1;
      @(negedge clk);
      wr_en = 1'b0; conv_done = 1'b0;
      chk("R5 collide no pulse", 16'(conv_start), 16'h0);
      rd(3'd4, v); chk("R5 collide idle", 16'(v[0]), 16'h0);
      rd(3'd2, lo); rd(3'd3, hi);
      chk("R5 collide result", 16'({hi, lo}), 16'h09E1);

      // R8 strap synchroniser delay, unmapped and idle reads
      uni_strap = 1'b0;
      repeat (3) @(negedge clk);
      uni_strap = 1'b1;
      @(negedge clk);
      rd(3'd4, v); chk("R8 strap not yet", 16'(v[1]), 16'h0);
      @(negedge clk);
      rd(3'd4, v); chk("R8 strap seen", 16'(v[1]), 16'h1);
      rd(3'd5, v); chk("R8 unmapped 5", 16'(v), 16'h0);
      rd(3'd7, v); chk("R8 unmapped 7", 16'(v), 16'h0);
      rd_addr = 3'd2; #1;
      chk("R8 rd_en low", 16'(rd_data), 16'h0);

      // R1 reset during conversion
      wr(3'd0, 8'h06);
      wr(3'd1, 8'h00);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      uni_strap = 1'b0;
      rd(3'd4, v); chk("R1 busy after reset", 16'(v[0]), 16'h0);
      rd(3'd2, lo); rd(3'd3, hi);
      chk("R1 result after reset", 16'({hi, lo}), 16'h0000);
      chk("R1 chan after reset", 16'(chan_sel), 16'h0);

      done_flag = 1;
      report();
      $finish;
   end
endmodule